// File: doc/BRIEF.md
# Multicycle Load/Store Sequencer

This block is the control unit of a small multicycle processor that runs word loads and word stores. A state register steps through a short sequence of phases. Each phase lasts one clock cycle, and each phase drives one fixed set of datapath enables and multiplexer selects. A fetch phase and a decode phase are shared by every instruction. After decode, the 6-bit opcode taken from the instruction register picks one of two paths:

- the load path, which has three phases;
- the store path, which has two phases.

Any other opcode sends the machine straight back to fetch.

The control outputs are a function of the current state alone. Two separate tables produce the signals:

- a narrow next-state table, indexed by the state and the opcode;
- a wide output table, indexed by the state only.

A synchronous reset returns the machine to fetch. The datapath connects these outputs to its PC register, instruction register, memory, register file and ALU multiplexers.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle is a fetch cycle. Fetch drives the control word {pc_we, ir_we, mem_we, reg_we, alu_a_sel, alu_b_sel[1:0], alu_op[1:0], pc_src, dst_sel} = 11'b1100_0010_000: PC write and IR write high, ALU A = PC (0), ALU B = constant 4 (01), op = add (00), PC source = ALU (0), destination = rd (0).
- R2: A fetch cycle is always followed by a decode cycle, whatever the opcode. Decode drives 11'b0000_0110_000: no writes, A = PC, B = shifted immediate (11).
- R3: In decode, an opcode other than 35 or 43 leads back to fetch on the next cycle, with no memory or register write in between.
- R4: In decode, opcode 43 starts the store path. The first store cycle drives 11'b0000_1100_000 (A = register A (1), B = sign-extended immediate (10)). The second store cycle drives 11'b0010_1100_000, with mem_we high for that one cycle only. Fetch follows. From fetch to the next fetch, a store takes 4 cycles.
- R5: In decode, opcode 35 starts the load path. It has two address/read cycles, each driving 11'b0000_1100_000, and then a write-back cycle driving 11'b0001_1100_001 (reg_we high for one cycle, destination = rt). Fetch follows. From fetch to the next fetch, a load takes 5 cycles.
- R6: The opcode is ignored in every state except decode. Changing it during fetch or during a load or store path does not change the output sequence.
- R7: At most one of mem_we, reg_we and ir_we is high in any cycle.
- R8: Asserting `rst` in the middle of a path abandons that path. The next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to fetch |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_we | output | 1 | PC register write enable |
| ir_we | output | 1 | Instruction register write enable |
| mem_we | output | 1 | Data memory write enable |
| reg_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 const 4, 10 sign-ext imm, 11 imm shifted by 2 |
| alu_op | output | 2 | ALU operation, 00 = add |
| pc_src | output | 1 | PC next source: 0 = ALU output, 1 = result register |
| dst_sel | output | 1 | Destination register: 0 = rd, 1 = rt |

## Verification
Each state has its own control word, except the load and store address cycles, which share one word. A wrong state therefore shows up at the outputs in the same cycle it is entered, or as a cycle too many or too few before the next fetch word. A missing or repeated write enable is visible one cycle after the faulty transition. A misrouted opcode decode is visible on the cycle right after decode.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_LOAD = 6'd35,
  parameter logic [OP_W-1:0] OP_STORE = 6'd43
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_we,
  output logic            ir_we,
  output logic            mem_we,
  output logic            reg_we,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_op,
  output logic            pc_src,
  output logic            dst_sel
);
  localparam int ST_W = 3;
  localparam int CW_W = 11;
  localparam logic [ST_W-1:0] S_FETCH = 3'd0;
  localparam logic [ST_W-1:0] S_DEC   = 3'd1;
  localparam logic [ST_W-1:0] S_ST1   = 3'd2;
  localparam logic [ST_W-1:0] S_ST2   = 3'd3;
  localparam logic [ST_W-1:0] S_LD1   = 3'd4;
  localparam logic [ST_W-1:0] S_LD2   = 3'd5;
  localparam logic [ST_W-1:0] S_LD3   = 3'd6;

  logic [ST_W-1:0] state, nxt;
  logic [CW_W-1:0] ctrl;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    case (state)
      S_FETCH: nxt = S_DEC;
      S_DEC: begin
        if (opcode == OP_LOAD)       nxt = S_LD1;
        else if (opcode == OP_STORE) nxt = S_ST1;
        else                         nxt = S_FETCH;
      end
      S_ST1:   nxt = S_ST2;
      S_LD1:   nxt = S_LD2;
      S_LD2:   nxt = S_LD3;
      default: nxt = S_FETCH;
    endcase
  end

  always_comb begin
    case (state)
      S_FETCH: ctrl = 11'b1100_0010_000;
      S_DEC:   ctrl = 11'b0000_0110_000;
      S_ST1,
      S_LD1,
      S_LD2:   ctrl = 11'b0000_1100_000;
      S_ST2:   ctrl = 11'b0010_1100_000;
      S_LD3:   ctrl = 11'b0001_1100_001;
      default: ctrl = '0;
    endcase
  end

  assign {pc_we, ir_we, mem_we, reg_we, alu_a_sel, alu_b_sel, alu_op, pc_src, dst_sel} = ctrl;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_LOAD = 6'd35,
  parameter logic [OP_W-1:0] OP_STORE = 6'd43
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic [2:0]      state,
  input logic            mem_we,
  input logic            reg_we,
  input logic            ir_we
);
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0) |=> (state == 3'd1));

  a_r3_unknown_op_returns: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && opcode != OP_LOAD && opcode != OP_STORE) |=> (state == 3'd0 && !mem_we && !reg_we));

  a_r4_store_writes_next: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2) |=> (state == 3'd3 && mem_we));

  a_r4_mem_we_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r5_reg_we_then_fetch: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (!reg_we && state == 3'd0));

  a_r7_writes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_we, reg_we, ir_we}) <= 1);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .state(state),
  .mem_we(mem_we), .reg_we(reg_we), .ir_we(ir_we)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  localparam logic [10:0] W_FETCH = 11'b1100_0010_000;
  localparam logic [10:0] W_DEC   = 11'b0000_0110_000;
  localparam logic [10:0] W_ADDR  = 11'b0000_1100_000;
  localparam logic [10:0] W_ST2   = 11'b0010_1100_000;
  localparam logic [10:0] W_LD3   = 11'b0001_1100_001;

  logic clk = 0, rst = 1;
  logic [5:0] opcode = 6'd0;
  logic pc_we, ir_we, mem_we, reg_we, alu_a_sel, pc_src, dst_sel;
  logic [1:0] alu_b_sel, alu_op;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mc_ctrl_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_we(pc_we), .ir_we(ir_we), .mem_we(mem_we), .reg_we(reg_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_src(pc_src), .dst_sel(dst_sel)
  );

  wire [10:0] cw = {pc_we, ir_we, mem_we, reg_we, alu_a_sel, alu_b_sel, alu_op, pc_src, dst_sel};

  task automatic chk(input string req, input logic [10:0] exp);
    checks++;
    if (cw !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, cw, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Assumes the bench stands at a negedge in fetch; noise is driven outside decode (R6)
  task automatic t_load(input logic [5:0] noise);
    int n = 0;
    chk("R2 fetch", W_FETCH);
    opcode = noise; @(negedge clk); n++;
    chk("R2 decode", W_DEC);
    opcode = 6'd35; @(negedge clk); n++;
    opcode = noise;
    chk("R5 load1", W_ADDR);
    @(negedge clk); n++;
    chk("R5 load2", W_ADDR);
    @(negedge clk); n++;
    chk("R5 load3 write-back", W_LD3);
    @(negedge clk); n++;
    chk("R5 back to fetch", W_FETCH);
    chk_int("R5 load cycles", n, 5);
  endtask

  task automatic t_store(input logic [5:0] noise);
    int n = 0;
    chk("R2 fetch", W_FETCH);
    opcode = noise; @(negedge clk); n++;
    chk("R2 decode", W_DEC);
    opcode = 6'd43; @(negedge clk); n++;
    opcode = noise;
    chk("R4 store1", W_ADDR);
    @(negedge clk); n++;
    chk("R4 store2 write", W_ST2);
    @(negedge clk); n++;
    chk("R4 back to fetch", W_FETCH);
    chk_int("R4 store cycles", n, 4);
  endtask

  task automatic t_other(input logic [5:0] op);
    chk("R2 fetch", W_FETCH);
    @(negedge clk);
    chk("R2 decode", W_DEC);
    opcode = op; @(negedge clk);
    chk("R3 unsupported op to fetch", W_FETCH);
  endtask

  task automatic t_reset_mid_load;
    chk("R2 fetch", W_FETCH);
    @(negedge clk);
    opcode = 6'd35; @(negedge clk);
    @(negedge clk);
    chk("R8 in load2", W_ADDR);
    rst = 1; @(negedge clk);
    rst = 0;
    chk("R8 reset abandons load", W_FETCH);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset gives fetch", W_FETCH);
    rst = 0;
    t_load(6'd43);
    t_store(6'd35);
    t_other(6'd0);
    t_other(6'd34);
    t_other(6'd63);
    t_store(6'd0);
    t_load(6'd35);
    t_reset_mid_load();
    t_store(6'd43);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule